// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces raster timing for a video output from eight programmable widths, four per axis: sync, back porch, active region and front porch. Each width is given as its length minus one in a 12-bit field, so a field of zero means one clock on the horizontal axis or one line on the vertical axis. A horizontal counter steps on every pixel clock. A vertical counter steps once at the end of each line. Both axes run through the same order: sync, back porch, active, front porch.

From the two counters the block drives a horizontal sync, a vertical sync and a data-enable strobe. Each of the three has its own polarity bit. It also gives the pixel path the column and row of the current active pixel, and a one-clock frame marker that fires as each frame's vertical sync begins. A run input starts the raster. Dropping run parks both counters at zero and holds every strobe at its inactive level.

All outputs are registered. There is no data stream through the block, so its pins are plain control and status levels with no handshake.

Top module: `vid_timing_gen`

## Requirements
- R1: While `rst_n` is low, `hsync_o`, `vsync_o`, `de_o`, `pos_x`, `pos_y` and `frame_evt` are all 0.
- R2: On a clock edge that samples `run` low, both counters return to zero. The same edge drives each strobe to its inactive level: `hsync_o` = !`pol_cfg[1]`, `vsync_o` = !`pol_cfg[0]`, `de_o` = !`pol_cfg[2]`. It also drives `pos_x` = `pos_y` = 0 and `frame_evt` = 0.
- R3: A line lasts (hs+1)+(hb+1)+(ha+1)+(hf+1) clocks, where hs, hb, ha and hf are `h_sync_w`, `h_back_w`, `h_act_w` and `h_front_w`. The horizontal regions come in the order sync, back porch, active, front porch.
- R4: `hsync_o` sits at the level `pol_cfg[1]` (1 = active high) for the first hs+1 clocks of each line. For the rest of the line it sits at the opposite level.
- R5: The vertical counter advances once per completed line. A frame holds (vs+1)+(vb+1)+(va+1)+(vf+1) lines, in the order sync, back porch, active, front porch. `vsync_o` sits at the level `pol_cfg[0]` during the first vs+1 lines and at the opposite level otherwise.
- R6: `de_o` sits at the level `pol_cfg[2]` only when both axes are inside their active regions. Otherwise it sits at the opposite level.
- R7: While data-enable is active, `pos_x` is the column within the active part of the line and `pos_y` is the row within the active lines, both counted from 0. Outside the active area both are 0.
- R8: `frame_evt` is a one-clock active-high pulse, raised exactly when the outputs show the first clock of a frame (the first clock of vertical sync). It fires once per frame.
- R9: Counting the edges that sample `run` high from k = 0, the outputs after edge k describe raster position k modulo the frame length. The position is line = p / line length and column = p mod line length.
- R10: Dropping `run` mid-frame and raising it again restarts the raster at position 0, with a frame pulse on the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Raster enable |
| h_sync_w | input | 12 | Horizontal sync width minus one |
| h_back_w | input | 12 | Horizontal back porch width minus one |
| h_act_w | input | 12 | Active pixels per line minus one |
| h_front_w | input | 12 | Horizontal front porch width minus one |
| v_sync_w | input | 12 | Vertical sync lines minus one |
| v_back_w | input | 12 | Vertical back porch lines minus one |
| v_act_w | input | 12 | Active lines minus one |
| v_front_w | input | 12 | Vertical front porch lines minus one |
| pol_cfg | input | 3 | Active levels: bit 0 vsync, bit 1 hsync, bit 2 data-enable |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| pos_x | output | 12 | Active column |
| pos_y | output | 12 | Active row |
| frame_evt | output | 1 | Frame-start pulse |

## Verification
Every output is due on the same rising edge that samples the counter position it describes. The edge that first samples `run` high therefore already shows position 0, and the edge that samples `run` low already shows the idle levels. The bench changes inputs only on falling edges and reads the outputs 5 ns after each rising edge. It steps a cycle index k per sampled-high edge and computes the expected strobes, coordinates and frame pulse from k, the line length and the frame length. It sweeps every position of several full frames for several width sets and all polarity patterns it uses, then repeats a mid-frame restart.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  // Region within one raster axis, in scan order.
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  // Bit positions inside the polarity vector.
  localparam int unsigned POL_VS = 0;
  localparam int unsigned POL_HS = 1;
  localparam int unsigned POL_DE = 2;
  localparam int unsigned POL_W  = 3;

  localparam int unsigned FIELD_W = 12;
endpackage

// File: rtl/vtg_axis.sv
// One raster axis: counts positions through sync, back porch, active and
// front porch, each programmed as length minus one.
module vtg_axis
  import vtg_pkg::*;
#(
  parameter int unsigned TW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          carry_in,
  input  logic [TW-1:0] w_sync,
  input  logic [TW-1:0] w_back,
  input  logic [TW-1:0] w_act,
  input  logic [TW-1:0] w_front,
  output logic          carry_out,
  output phase_e        phase,
  output logic [TW-1:0] idx
);
  localparam int unsigned CW = TW + 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] sync_end, back_end, act_end, last_pos;
  logic          at_last;

  assign sync_end = CW'(w_sync) + CW'(1);
  assign back_end = sync_end + CW'(w_back) + CW'(1);
  assign act_end  = back_end + CW'(w_act) + CW'(1);
  assign last_pos = act_end + CW'(w_front);
  assign at_last  = (cnt == last_pos);
  assign carry_out = carry_in & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (carry_in) begin
      cnt <= at_last ? '0 : cnt + CW'(1);
    end
  end

  always_comb begin
    if (cnt < sync_end)      phase = PH_SYNC;
    else if (cnt < back_end) phase = PH_BACK;
    else if (cnt < act_end)  phase = PH_ACT;
    else                     phase = PH_FRONT;
  end

  assign idx = (phase == PH_ACT) ? TW'(cnt - back_end) : '0;
endmodule

// File: rtl/vtg_drive.sv
// Output stage: turns the two axis phases into registered strobes with
// programmable active levels, plus coordinates and the frame marker.
module vtg_drive
  import vtg_pkg::*;
#(
  parameter int unsigned TW = FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [POL_W-1:0] pol,
  input  phase_e           h_phase,
  input  phase_e           v_phase,
  input  logic [TW-1:0]    h_idx,
  input  logic [TW-1:0]    v_idx,
  input  logic             frame_wrap,
  output logic             hsync_q,
  output logic             vsync_q,
  output logic             de_q,
  output logic [TW-1:0]    x_q,
  output logic [TW-1:0]    y_q,
  output logic             evt_q
);
  logic hs_on, vs_on, de_on;
  logic frame_pend;

  assign hs_on = (h_phase == PH_SYNC);
  assign vs_on = (v_phase == PH_SYNC);
  assign de_on = (h_phase == PH_ACT) && (v_phase == PH_ACT);

  // Marks that the next registered position is the first of a frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_pend <= 1'b1;
    else        frame_pend <= !run || frame_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_q <= 1'b0;
      vsync_q <= 1'b0;
      de_q    <= 1'b0;
      x_q     <= '0;
      y_q     <= '0;
      evt_q   <= 1'b0;
    end else if (!run) begin
      hsync_q <= !pol[POL_HS];
      vsync_q <= !pol[POL_VS];
      de_q    <= !pol[POL_DE];
      x_q     <= '0;
      y_q     <= '0;
      evt_q   <= 1'b0;
    end else begin
      hsync_q <= hs_on ? pol[POL_HS] : !pol[POL_HS];
      vsync_q <= vs_on ? pol[POL_VS] : !pol[POL_VS];
      de_q    <= de_on ? pol[POL_DE] : !pol[POL_DE];
      x_q     <= de_on ? h_idx : '0;
      y_q     <= de_on ? v_idx : '0;
      evt_q   <= frame_pend;
    end
  end
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int unsigned TW = FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TW-1:0]    h_sync_w,
  input  logic [TW-1:0]    h_back_w,
  input  logic [TW-1:0]    h_act_w,
  input  logic [TW-1:0]    h_front_w,
  input  logic [TW-1:0]    v_sync_w,
  input  logic [TW-1:0]    v_back_w,
  input  logic [TW-1:0]    v_act_w,
  input  logic [TW-1:0]    v_front_w,
  input  logic [POL_W-1:0] pol_cfg,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [TW-1:0]    pos_x,
  output logic [TW-1:0]    pos_y,
  output logic             frame_evt
);
  phase_e        h_phase, v_phase;
  logic [TW-1:0] h_idx, v_idx;
  logic          line_end, frame_end;

  vtg_axis #(.TW(TW)) u_hax (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .carry_in  (1'b1),
    .w_sync    (h_sync_w),
    .w_back    (h_back_w),
    .w_act     (h_act_w),
    .w_front   (h_front_w),
    .carry_out (line_end),
    .phase     (h_phase),
    .idx       (h_idx)
  );

  vtg_axis #(.TW(TW)) u_vax (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .carry_in  (line_end),
    .w_sync    (v_sync_w),
    .w_back    (v_back_w),
    .w_act     (v_act_w),
    .w_front   (v_front_w),
    .carry_out (frame_end),
    .phase     (v_phase),
    .idx       (v_idx)
  );

  vtg_drive #(.TW(TW)) u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .pol        (pol_cfg),
    .h_phase    (h_phase),
    .v_phase    (v_phase),
    .h_idx      (h_idx),
    .v_idx      (v_idx),
    .frame_wrap (frame_end),
    .hsync_q    (hsync_o),
    .vsync_q    (vsync_o),
    .de_q       (de_o),
    .x_q        (pos_x),
    .y_q        (pos_y),
    .evt_q      (frame_evt)
  );
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
  import vtg_pkg::*;
#(
  parameter int unsigned TW = FIELD_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [POL_W-1:0] pol_cfg,
  input logic             hsync_o,
  input logic             vsync_o,
  input logic             de_o,
  input logic [TW-1:0]    pos_x,
  input logic [TW-1:0]    pos_y,
  input logic             frame_evt
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(run) |-> (hsync_o == !$past(pol_cfg[POL_HS])) &&
                    (vsync_o == !$past(pol_cfg[POL_VS])) &&
                    (de_o == !$past(pol_cfg[POL_DE])) &&
                    (pos_x == '0) && (pos_y == '0) && !frame_evt);

  // R6
  de_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (de_o == $past(pol_cfg[POL_DE])) |->
      (hsync_o != $past(pol_cfg[POL_HS])) && (vsync_o != $past(pol_cfg[POL_VS])));

  // R7
  pos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (de_o != $past(pol_cfg[POL_DE])) |-> (pos_x == '0) && (pos_y == '0));

  // R8
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    frame_evt |=> !frame_evt);

  // R8
  evt_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    frame_evt |-> (vsync_o == $past(pol_cfg[POL_VS])) &&
                  (hsync_o == $past(pol_cfg[POL_HS])));
endmodule

bind vid_timing_gen vtg_chk #(.TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .pol_cfg   (pol_cfg),
  .hsync_o   (hsync_o),
  .vsync_o   (vsync_o),
  .de_o      (de_o),
  .pos_x     (pos_x),
  .pos_y     (pos_y),
  .frame_evt (frame_evt)
);

// File: tb/sim_vid_timing_gen.sv
`timescale 1ns/1ps
module sim_vid_timing_gen;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic [TW-1:0] h_sync_w = '0, h_back_w = '0, h_act_w = '0, h_front_w = '0;
  logic [TW-1:0] v_sync_w = '0, v_back_w = '0, v_act_w = '0, v_front_w = '0;
  logic [2:0]    pol_cfg = 3'b000;
  logic          hsync_o, vsync_o, de_o, frame_evt;
  logic [TW-1:0] pos_x, pos_y;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vid_timing_gen #(.TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run),
    .h_sync_w(h_sync_w), .h_back_w(h_back_w), .h_act_w(h_act_w), .h_front_w(h_front_w),
    .v_sync_w(v_sync_w), .v_back_w(v_back_w), .v_act_w(v_act_w), .v_front_w(v_front_w),
    .pol_cfg(pol_cfg),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pos_x(pos_x), .pos_y(pos_y), .frame_evt(frame_evt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // R2: idle levels one edge after run is sampled low.
  task automatic chk_idle(input string tag);
    chk({tag, " hsync"}, 32'(hsync_o), 32'(!pol_cfg[1]));
    chk({tag, " vsync"}, 32'(vsync_o), 32'(!pol_cfg[0]));
    chk({tag, " de"},    32'(de_o),    32'(!pol_cfg[2]));
    chk({tag, " x"},     32'(pos_x),   0);
    chk({tag, " y"},     32'(pos_y),   0);
    chk({tag, " evt"},   32'(frame_evt), 0);
  endtask

  // Run the raster for n sampled-high edges starting at position 0 and
  // compare every output against the arithmetic model (R3..R9).
  task automatic sweep(input int hs, input int hb, input int ha, input int hf,
                       input int vs, input int vb, input int va, input int vf,
                       input logic [2:0] pol, input int n, input string tag);
    int line_len, frame_len;
    @(negedge clk);
    run = 1'b0;
    h_sync_w = TW'(hs); h_back_w = TW'(hb); h_act_w = TW'(ha); h_front_w = TW'(hf);
    v_sync_w = TW'(vs); v_back_w = TW'(vb); v_act_w = TW'(va); v_front_w = TW'(vf);
    pol_cfg = pol;
    @(posedge clk); #5;
    chk_idle({tag, " R2 idle"});
    @(negedge clk);
    run = 1'b1;
    line_len  = hs + hb + ha + hf + 4;
    frame_len = line_len * (vs + vb + va + vf + 4);
    for (int k = 0; k < n; k++) begin
      int p, col, row, hbe, vbe;
      logic h_in_act, v_in_act, de_exp;
      @(posedge clk); #5;
      p   = k % frame_len;
      col = p % line_len;
      row = p / line_len;
      hbe = hs + hb + 2;
      vbe = vs + vb + 2;
      h_in_act = (col >= hbe) && (col < hbe + ha + 1);
      v_in_act = (row >= vbe) && (row < vbe + va + 1);
      de_exp = h_in_act && v_in_act;
      chk({tag, " R3 R4 hsync"}, 32'(hsync_o), 32'((col < hs + 1) ? pol[1] : !pol[1]));
      chk({tag, " R5 vsync"},    32'(vsync_o), 32'((row < vs + 1) ? pol[0] : !pol[0]));
      chk({tag, " R6 de"},       32'(de_o),    32'(de_exp ? pol[2] : !pol[2]));
      chk({tag, " R7 x"},        32'(pos_x),   de_exp ? 32'(col - hbe) : 0);
      chk({tag, " R7 y"},        32'(pos_y),   de_exp ? 32'(row - vbe) : 0);
      chk({tag, " R8 R9 evt"},   32'(frame_evt), 32'(p == 0));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    // R1: outputs low during reset
    repeat (3) @(posedge clk);
    #5;
    chk("R1 hsync", 32'(hsync_o), 0);
    chk("R1 vsync", 32'(vsync_o), 0);
    chk("R1 de",    32'(de_o),    0);
    chk("R1 x",     32'(pos_x),   0);
    chk("R1 y",     32'(pos_y),   0);
    chk("R1 evt",   32'(frame_evt), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Smallest raster: every width one unit.
    sweep(0, 0, 0, 0, 0, 0, 0, 0, 3'b010, 40, "cfgMin");
    // Mixed widths, every polarity pattern.
    for (int pv = 0; pv < 8; pv++)
      sweep(1, 0, 3, 1, 0, 1, 2, 0, 3'(pv), 130, "cfgA");
    // Wider raster.
    sweep(3, 2, 9, 1, 1, 1, 4, 2, 3'b101, 2 * 228 + 7, "cfgB");

    // R10: restart mid-frame resumes at position 0.
    sweep(2, 1, 5, 0, 0, 2, 3, 1, 3'b011, 75, "R10 first");
    @(negedge clk);
    run = 1'b0;
    @(posedge clk); #5;
    chk_idle("R10 R2 stop");
    sweep(2, 1, 5, 0, 0, 2, 3, 1, 3'b011, 240, "R10 restart");

    @(negedge clk);
    run = 1'b0;
    @(posedge clk); #5;
    chk_idle("R2 end");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule